// File: doc/BRIEF.md
# Alarm Timer with 64-bit Time Base

This block keeps a 64-bit time count that steps by one in each cycle where a tick-enable input is high. Software reaches it over a plain 32-bit register bus with an address, write and read strobes, write data and combinational read data. The count can be loaded as a whole 64-bit value through two halves. It can be read as a coherent pair, where reading the low half freezes the matching high half, or it can be read live with no side effects.

Four alarms compare their 32-bit target with the low word of the count. Writing a target arms that alarm. When an armed alarm matches, it sets its raw interrupt bit and disarms itself. The raw bits pass through an enable mask and a force mask to form a status word, and the OR of that word drives one interrupt line. The count can be held by a software pause bit. It can also be held by either of two processor debug-active inputs, each gated by its own enable bit.

Top module: `tick_timer64`

## Requirements
- R1: After reset the count, the armed bits, the raw, enable and force masks and the pause bit are all 0. Both debug-pause enables are 1, so address 11 reads 0x6.
- R2: A write to address 0 only stages the high word and leaves the count unchanged. A write to address 1 loads the count with {staged high, written low} at that edge.
- R3: The count rises by exactly 1 at each edge where the tick input is high and no pause applies. Carry passes from bit 31 into bit 32.
- R4: Addresses 10 and 9 return the live low and high words with no side effect. A read strobe on address 3 returns the live low word and copies the live high word into a holding register. Address 2 returns that held word.
- R5: Writing address 4+k (k = 0..3) stores target k and arms alarm k. Bit k of address 8 shows the armed state.
- R6: If alarm k is armed and its target equals bits 31:0 of the count at an edge, that edge sets raw bit k (address 13) and clears armed bit k.
- R7: Writing a 1 to bit k of address 8 disarms alarm k, and no raw bit is set when the count later reaches its target.
- R8: While bit 0 of address 12 is 1, the count holds its value even with tick high.
- R9: Debug input bit j holds the count while it is high and enable bit j+1 of address 11 is 1. With that enable bit at 0, the input has no effect.
- R10: Address 16 reads (raw AND enable) OR force, with enable at address 14 and force at address 15. The irq output is 1 exactly when that word is nonzero.
- R11: Writing a 1 to a bit of address 13 clears that raw bit. Bits written as 0 keep their value.
- R12: Alarm comparison keeps running while the count is held, so an alarm whose target equals the held value fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| tick | input | 1 | Count enable for one cycle |
| dbgActive | input | 2 | Debug-active flag from each of two processors |
| busAddr | input | 5 | Register word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (needed for the latching read side effect) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| irq | output | 1 | OR of all interrupt status bits |

## Verification
The assertions assume that tick is the only source of counting and that a write and a read never share a cycle. They also assume the strobes are clean single-cycle levels sampled at the rising edge. The stimulus applies one bus operation at a time, driven on the falling edge, and changes tick and the debug inputs only between those operations. A bench model can then predict the count exactly. Alarm targets are placed a few ticks ahead of a loaded time, so each firing lands on a known edge.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W    = 32;
  localparam int TIME_W    = 2 * DATA_W;
  localparam int NUM_ALARM = 4;
  localparam int ADDR_W    = 5;
  localparam int NUM_DBG   = 2;

  localparam int A_TIME_HI_W = 0;
  localparam int A_TIME_LO_W = 1;
  localparam int A_TIME_HI_R = 2;
  localparam int A_TIME_LO_R = 3;
  localparam int A_ALARM0    = 4;
  localparam int A_ARMED     = A_ALARM0 + NUM_ALARM;
  localparam int A_RAW_HI    = A_ARMED + 1;
  localparam int A_RAW_LO    = A_ARMED + 2;
  localparam int A_DBG_EN    = A_ARMED + 3;
  localparam int A_PAUSE     = A_ARMED + 4;
  localparam int A_INT_RAW   = A_ARMED + 5;
  localparam int A_INT_EN    = A_ARMED + 6;
  localparam int A_INT_FORCE = A_ARMED + 7;
  localparam int A_INT_STAT  = A_ARMED + 8;

  typedef struct packed {
    logic                 wrTimeHi;
    logic                 wrTimeLo;
    logic                 rdTimeLo;
    logic [NUM_ALARM-1:0] wrAlarm;
    logic                 wrArmed;
    logic                 wrDbgEn;
    logic                 wrPause;
    logic                 wrIntRaw;
    logic                 wrIntEn;
    logic                 wrIntForce;
  } regStrobe_t;

  typedef struct packed {
    logic [TIME_W-1:0]                 timeNow;
    logic [DATA_W-1:0]                 heldHi;
    logic [NUM_ALARM-1:0][DATA_W-1:0]  target;
    logic [NUM_ALARM-1:0]              armed;
    logic [NUM_DBG-1:0]                dbgEn;
    logic                              pause;
    logic [NUM_ALARM-1:0]              intRaw;
    logic [NUM_ALARM-1:0]              intEn;
    logic [NUM_ALARM-1:0]              intForce;
    logic [NUM_ALARM-1:0]              intStat;
  } regView_t;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int AddrW = ADDR_W,
  parameter int DataW = DATA_W
) (
  input  logic [AddrW-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  input  regView_t         view,
  output regStrobe_t       strobe,
  output logic [DataW-1:0] busRdata
);
  localparam int HalfW = DataW;

  function automatic logic hit(input logic [AddrW-1:0] a, input int target);
    return a == AddrW'(target);
  endfunction

  always_comb begin
    strobe            = '0;
    strobe.wrTimeHi   = busWr && hit(busAddr, A_TIME_HI_W);
    strobe.wrTimeLo   = busWr && hit(busAddr, A_TIME_LO_W);
    strobe.rdTimeLo   = busRd && hit(busAddr, A_TIME_LO_R);
    strobe.wrArmed    = busWr && hit(busAddr, A_ARMED);
    strobe.wrDbgEn    = busWr && hit(busAddr, A_DBG_EN);
    strobe.wrPause    = busWr && hit(busAddr, A_PAUSE);
    strobe.wrIntRaw   = busWr && hit(busAddr, A_INT_RAW);
    strobe.wrIntEn    = busWr && hit(busAddr, A_INT_EN);
    strobe.wrIntForce = busWr && hit(busAddr, A_INT_FORCE);
    for (int k = 0; k < NUM_ALARM; k++) begin
      strobe.wrAlarm[k] = busWr && hit(busAddr, A_ALARM0 + k);
    end
  end

  always_comb begin
    busRdata = '0;
    if (hit(busAddr, A_TIME_HI_R))  busRdata = view.heldHi;
    if (hit(busAddr, A_TIME_LO_R))  busRdata = view.timeNow[HalfW-1:0];
    if (hit(busAddr, A_RAW_HI))     busRdata = view.timeNow[2*HalfW-1:HalfW];
    if (hit(busAddr, A_RAW_LO))     busRdata = view.timeNow[HalfW-1:0];
    if (hit(busAddr, A_ARMED))      busRdata = DataW'(view.armed);
    if (hit(busAddr, A_DBG_EN))     busRdata = DataW'({view.dbgEn, 1'b0});
    if (hit(busAddr, A_PAUSE))      busRdata = DataW'(view.pause);
    if (hit(busAddr, A_INT_RAW))    busRdata = DataW'(view.intRaw);
    if (hit(busAddr, A_INT_EN))     busRdata = DataW'(view.intEn);
    if (hit(busAddr, A_INT_FORCE))  busRdata = DataW'(view.intForce);
    if (hit(busAddr, A_INT_STAT))   busRdata = DataW'(view.intStat);
    for (int k = 0; k < NUM_ALARM; k++) begin
      if (hit(busAddr, A_ALARM0 + k)) busRdata = view.target[k];
    end
  end
endmodule

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int DataW  = DATA_W,
  parameter int Alarms = NUM_ALARM,
  parameter int DbgN   = NUM_DBG
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic [DbgN-1:0]  dbgActive,
  input  logic [DataW-1:0] wdata,
  input  regStrobe_t       strobe,
  output regView_t         view,
  output logic             irq
);
  localparam int TimeW = 2 * DataW;

  logic [TimeW-1:0]              timeVal;
  logic [DataW-1:0]              stageHi;
  logic [DataW-1:0]              heldHi;
  logic [Alarms-1:0][DataW-1:0]  targetReg;
  logic [Alarms-1:0]             armedReg;
  logic [Alarms-1:0]             fire;
  logic [DbgN-1:0]               dbgEnReg;
  logic                          pauseReg;
  logic [Alarms-1:0]             rawReg;
  logic [Alarms-1:0]             enReg;
  logic [Alarms-1:0]             forceReg;
  logic [Alarms-1:0]             statVec;
  logic                          paused;

  assign paused  = pauseReg || |(dbgEnReg & dbgActive);
  assign statVec = (rawReg & enReg) | forceReg;
  assign irq     = |statVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeVal <= '0;
      stageHi <= '0;
      heldHi  <= '0;
    end else begin
      if (strobe.wrTimeHi) stageHi <= wdata;
      if (strobe.rdTimeLo) heldHi  <= timeVal[TimeW-1:DataW];
      if (strobe.wrTimeLo)         timeVal <= {stageHi, wdata};
      else if (tick && !paused)    timeVal <= timeVal + TimeW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgEnReg <= '1;
      pauseReg <= 1'b0;
      rawReg   <= '0;
      enReg    <= '0;
      forceReg <= '0;
    end else begin
      if (strobe.wrDbgEn)    dbgEnReg <= wdata[DbgN:1];
      if (strobe.wrPause)    pauseReg <= wdata[0];
      if (strobe.wrIntEn)    enReg    <= wdata[Alarms-1:0];
      if (strobe.wrIntForce) forceReg <= wdata[Alarms-1:0];
      rawReg <= (rawReg & ~(strobe.wrIntRaw ? wdata[Alarms-1:0] : '0)) | fire;
    end
  end

  for (genvar g = 0; g < Alarms; g++) begin : gAlarm
    assign fire[g] = armedReg[g] && (targetReg[g] == timeVal[DataW-1:0]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        targetReg[g] <= '0;
        armedReg[g]  <= 1'b0;
      end else if (strobe.wrAlarm[g]) begin
        targetReg[g] <= wdata;
        armedReg[g]  <= 1'b1;
      end else if (fire[g] || (strobe.wrArmed && wdata[g])) begin
        armedReg[g]  <= 1'b0;
      end
    end

    // R6: a match latches the raw bit
    a_r6_fire_sets_raw: assert property (@(posedge clk) disable iff (!rstN)
      fire[g] |=> rawReg[g]);
    // R6: a match disarms unless re-armed in the same cycle
    a_r6_self_disarm: assert property (@(posedge clk) disable iff (!rstN)
      (fire[g] && !strobe.wrAlarm[g]) |=> !armedReg[g]);
    // R5: arming only comes from a target write
    a_r5_arm_by_write: assert property (@(posedge clk) disable iff (!rstN)
      $rose(armedReg[g]) |-> $past(strobe.wrAlarm[g]));
  end

  // R3: one step per enabled tick
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !paused && !strobe.wrTimeLo) |=> timeVal == $past(timeVal) + TimeW'(1));
  // R8: no movement while held
  a_r8_hold_when_paused: assert property (@(posedge clk) disable iff (!rstN)
    (paused && !strobe.wrTimeLo) |=> $stable(timeVal));
  // R2: a low write lands its data in the low word
  a_r2_low_commit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrTimeLo |=> timeVal[DataW-1:0] == $past(wdata));
  // R10: any forced bit raises irq
  a_r10_force_irq: assert property (@(posedge clk) disable iff (!rstN)
    (|forceReg) |-> irq);

  always_comb begin
    view          = '0;
    view.timeNow  = timeVal;
    view.heldHi   = heldHi;
    view.target   = targetReg;
    view.armed    = armedReg;
    view.dbgEn    = dbgEnReg;
    view.pause    = pauseReg;
    view.intRaw   = rawReg;
    view.intEn    = enReg;
    view.intForce = forceReg;
    view.intStat  = statVec;
  end
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [NUM_DBG-1:0] dbgActive,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  regStrobe_t strobe;
  regView_t   view;

  tick_timer_ctrl #(.AddrW(ADDR_W), .DataW(DATA_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .view    (view),
    .strobe  (strobe),
    .busRdata(busRdata)
  );

  tick_timer_dp #(.DataW(DATA_W), .Alarms(NUM_ALARM), .DbgN(NUM_DBG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .dbgActive(dbgActive),
    .wdata    (busWdata),
    .strobe   (strobe),
    .view     (view),
    .irq      (irq)
  );
endmodule

// File: tb/test_tick_timer64.sv
`timescale 1ns/1ps
module test_tick_timer64;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  dbgActive = 2'b00;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  always #10 clk = ~clk;

  tick_timer64 i_tick_timer64 (
    .clk(clk), .rstN(rstN), .tick(tick), .dbgActive(dbgActive),
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  int nRun = 0;
  int nFail = 0;
  logic [63:0] expTime;
  logic [31:0] rv, rv2;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic loadTime(input logic [63:0] v);
    wr(5'd0, v[63:32]);
    wr(5'd1, v[31:0]);
    expTime = v;
  endtask

  task automatic chkTime(input string req);
    logic [31:0] lo, hi;
    rd(5'd10, lo);
    rd(5'd9, hi);
    chk(req, {hi, lo}, expTime);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    expTime = '0;

    // R1 reset state
    chkTime("R1 time");
    rd(5'd8, rv);  chk("R1 armed", rv, 0);
    rd(5'd11, rv); chk("R1 dbg enables", rv, 32'h6);
    rd(5'd12, rv); chk("R1 pause", rv, 0);
    rd(5'd13, rv); chk("R1 raw", rv, 0);
    rd(5'd14, rv); chk("R1 enable", rv, 0);
    rd(5'd15, rv); chk("R1 force", rv, 0);
    rd(5'd16, rv); chk("R1 status", rv, 0);
    chk("R1 irq", irq, 0);

    // R2 staged high, commit on low
    wr(5'd0, 32'h12345678);
    chkTime("R2 staged only");
    wr(5'd1, 32'hFFFFFFFC);
    expTime = 64'h12345678_FFFFFFFC;
    chkTime("R2 commit");

    // R3 tick sweep across the carry
    for (int n = 0; n < 8; n++) begin
      ticks(n);
      expTime += 64'(n);
      chkTime("R3 step");
    end

    // R4 coherent latched read
    loadTime(64'h00000005_FFFFFFFF);
    rd(5'd3, rv);  chk("R4 latched low", rv, 32'hFFFFFFFF);
    ticks(1); expTime += 1;
    rd(5'd9, rv);  chk("R4 raw high live", rv, 32'h6);
    rd(5'd2, rv);  chk("R4 held high", rv, 32'h5);
    rd(5'd10, rv); rd(5'd2, rv2);
    chk("R4 raw read no side effect", rv2, 32'h5);

    // R5 R6 R11 each alarm in turn
    for (int k = 0; k < 4; k++) begin
      loadTime(64'd1000);
      wr(5'(4 + k), 32'd1005 + 32'(k));
      rd(5'd8, rv);  chk("R5 armed bit", rv, 32'(1 << k));
      rd(5'(4 + k), rv); chk("R5 target readback", rv, 32'd1005 + 32'(k));
      ticks(4 + k);
      rd(5'd13, rv); chk("R6 no early fire", rv, 0);
      ticks(1);
      @(negedge clk);
      rd(5'd13, rv); chk("R6 raw set on match", rv, 32'(1 << k));
      rd(5'd8, rv);  chk("R6 disarmed on match", rv, 0);
      wr(5'd13, 32'h0);
      rd(5'd13, rv); chk("R11 zero write keeps", rv, 32'(1 << k));
      wr(5'd13, 32'(1 << k));
      rd(5'd13, rv); chk("R11 one write clears", rv, 0);
    end

    // R7 disarm without firing
    wr(5'd4, 32'd2000);
    wr(5'd5, 32'd2000);
    wr(5'd8, 32'h1);
    rd(5'd8, rv);  chk("R7 only bit0 disarmed", rv, 32'h2);
    loadTime(64'd2000);
    @(negedge clk);
    rd(5'd13, rv); chk("R7 disarmed alarm silent", rv, 32'h2);
    wr(5'd13, 32'hF);

    // R8 pause bit
    loadTime(64'd500);
    wr(5'd12, 32'h1);
    ticks(5);
    chkTime("R8 held");

    // R12 compare while paused
    loadTime(64'd3000);
    wr(5'd5, 32'd3000);
    @(negedge clk);
    rd(5'd13, rv); chk("R12 fire while paused", rv, 32'h2);
    wr(5'd12, 32'h0);
    ticks(2); expTime += 2;
    chkTime("R8 resumes");

    // R9 debug pause
    dbgActive = 2'b01; ticks(3);
    chkTime("R9 debug0 holds");
    dbgActive = 2'b10; ticks(3);
    chkTime("R9 debug1 holds");
    wr(5'd11, 32'h0);
    dbgActive = 2'b11; ticks(3); expTime += 3;
    chkTime("R9 disabled debug ignored");
    rd(5'd11, rv); chk("R9 enable readback", rv, 0);
    wr(5'd11, 32'h6);
    dbgActive = 2'b00;

    // R10 status sweep with raw = 0x2
    for (int e = 0; e < 16; e++) begin
      for (int f = 0; f < 16; f++) begin
        wr(5'd14, 32'(e));
        wr(5'd15, 32'(f));
        rd(5'd16, rv);
        chk("R10 status", rv, 32'((2 & e) | f));
        chk("R10 irq", irq, 64'(((2 & e) | f) != 0));
      end
    end
    wr(5'd15, 32'h0);
    wr(5'd13, 32'h2);
    @(negedge clk);
    chk("R11 irq after clear", irq, 0);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule